// File: doc/BRIEF.md
# Dual Coherent Real-Input Downconverter

This block takes two real, signed sample streams from a pair of converters and brings each one down to baseband. A single numerically controlled oscillator feeds both mixers, so the two channels stay phase-locked to each other. Each channel's complex product is reduced in rate by an integrate-and-dump stage. The four results of every dump are merged into one word stream for a receive FIFO.

The host sets three controls: a phase increment, a decimation count and an enable. Input routing is fixed. Converter A feeds channel 1 and converter B feeds channel 2, and each channel's quadrature input is zero. Since four words leave per decimated sample, the block raises any decimation count below eight to eight. When the consumer cannot keep up, a whole set of four is dropped, so word alignment is never lost.

Top module: `dual_rx_downconv`

## Requirements
- R1: One phase accumulator, cleared while disabled, adds the phase increment on every enabled cycle. Its top 10 bits address a full-cycle 1024-entry table holding round(32767*sin(2*pi*k/1024)). The cosine is the entry at address+256 (mod 1024). Both channels use this same oscillator.
- R2: The routing is fixed and cannot be changed. Channel 1 mixes input A and channel 2 mixes input B. Each I product is floor((x*cos)/2^15) and each Q product is floor(-(x*sin)/2^15), where x is the signed input sample.
- R3: Each integrator sums exactly D consecutive mixer products. It then outputs the sum and restarts from zero with the next product.
- R4: A programmed decimation count below 8 behaves exactly like 8.
- R5: A new decimation count is taken up only when a dump occurs. The block integration in progress completes with the old count.
- R6: Each dumped sum S is turned into round(S/2^s), with s = floor(log2 D). This means adding 2^(s-1) and then applying an arithmetic right shift by s. The result is saturated to the signed 16-bit range.
- R7: Each dump produces four output words in the order I1, Q1, I2, Q2.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R9: A dump can be accepted only if the output buffer is empty or its last word leaves in that same cycle. Any other dump is dropped whole, and the sticky overrun flag is set.
- R10: While enable is low, out_valid and overrun are low and the phase, integrators, counters and buffer are cleared. After enable returns, the first word is an I1. Reset leaves the same state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_a | input | ADC_W | Signed samples for channel 1 |
| rx_b | input | ADC_W | Signed samples for channel 2 |
| phase_inc | input | PHASE_W | Shared oscillator phase increment |
| dec_rate | input | DEC_W | Decimation count (values below 8 act as 8) |
| enable | input | 1 | Run enable; low clears the datapath |
| out_ready | input | 1 | Consumer ready |
| out_data | output | OUT_W | Interleaved word I1, Q1, I2, Q2 |
| out_valid | output | 1 | out_data holds a word |
| overrun | output | 1 | Sticky flag: a dump set was dropped |

## Verification
The bench builds the block with 16-bit inputs, a 32-bit phase, a 1024-entry 16-bit table and an 8-bit decimation count. With 16-bit inputs, full-scale samples integrated over 15 cycles overshoot the 16-bit output range in both directions, so the saturation paths can be exercised. The 8-bit count allows rates from the clamped minimum of 8 up to 20 within a short run. With a zero phase increment the oscillator stays on its peak cosine entry. Random and held-low ready patterns drive the buffer into both the back-pressure case and the whole-set drop case.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  localparam int NUM_CH  = 2;
  localparam int LANES   = 2 * NUM_CH;
  localparam int MIN_DEC = 2 * LANES;
endpackage

// File: rtl/ddc_nco.sv
module ddc_nco #(
  parameter int PHASE_W = 32,
  parameter int LUT_AW  = 10,
  parameter int LUT_DW  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic [PHASE_W-1:0]       inc,
  output logic signed [LUT_DW-1:0] sin_q,
  output logic signed [LUT_DW-1:0] cos_q
);
  localparam int DEPTH = 1 << LUT_AW;
  localparam logic [LUT_AW-1:0] QUARTER = LUT_AW'(DEPTH / 4);
  localparam real TWO_PI = 2.0 * 3.14159265358979;

  logic [PHASE_W-1:0] phase_q;
  logic [LUT_AW-1:0]  addr_s, addr_c;
  logic signed [LUT_DW-1:0] wave_rom [DEPTH];

  function automatic logic signed [LUT_DW-1:0] wave_entry(input int k);
    real amp, v;
    amp = real'((2 ** (LUT_DW - 1)) - 1);
    v   = amp * $sin(TWO_PI * real'(k) / real'(DEPTH));
    return LUT_DW'($rtoi($floor(v + 0.5)));
  endfunction

  initial begin
    for (int k = 0; k < DEPTH; k++) wave_rom[k] = wave_entry(k);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) phase_q <= '0;
    else            phase_q <= phase_q + inc;
  end

  assign addr_s = phase_q[PHASE_W-1 -: LUT_AW];
  assign addr_c = addr_s + QUARTER;

  always_ff @(posedge clk) begin
    sin_q <= wave_rom[addr_s];
    cos_q <= wave_rom[addr_c];
  end
endmodule

// File: rtl/ddc_mixer.sv
module ddc_mixer #(
  parameter int ADC_W  = 14,
  parameter int LUT_DW = 16,
  parameter int MIX_W  = ADC_W + 1
) (
  input  logic                     clk,
  input  logic [ADC_W-1:0]         x_in,
  input  logic signed [LUT_DW-1:0] sin_v,
  input  logic signed [LUT_DW-1:0] cos_v,
  output logic signed [MIX_W-1:0]  i_out,
  output logic signed [MIX_W-1:0]  q_out
);
  localparam int PW = ADC_W + LUT_DW;

  logic signed [ADC_W-1:0] x_q;
  logic signed [PW-1:0]    prod_i, prod_q, shr_i, shr_q;

  always_ff @(posedge clk) x_q <= $signed(x_in);

  always_comb begin
    prod_i = x_q * cos_v;
    prod_q = -(x_q * sin_v);
    shr_i  = prod_i >>> (LUT_DW - 1);
    shr_q  = prod_q >>> (LUT_DW - 1);
  end

  always_ff @(posedge clk) begin
    i_out <= shr_i[MIX_W-1:0];
    q_out <= shr_q[MIX_W-1:0];
  end
endmodule

// File: rtl/ddc_dump_ctrl.sv
module ddc_dump_ctrl #(
  parameter int DEC_W   = 8,
  parameter int MIN_DEC = 8,
  parameter int SH_W    = $clog2(DEC_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             adv,
  input  logic [DEC_W-1:0] dec_in,
  output logic             last,
  output logic [SH_W-1:0]  shift
);
  logic [DEC_W-1:0] cnt_q, cur_q, dec_clamped;

  assign dec_clamped = (dec_in < DEC_W'(MIN_DEC)) ? DEC_W'(MIN_DEC) : dec_in;
  assign last = en && adv && (cnt_q == cur_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      cur_q <= DEC_W'(MIN_DEC);
    end else if (!en) begin
      cnt_q <= '0;
      cur_q <= dec_clamped;
    end else if (adv) begin
      if (last) begin
        cnt_q <= '0;
        cur_q <= dec_clamped;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    shift = '0;
    for (int i = 0; i < DEC_W; i++) if (cur_q[i]) shift = SH_W'(i);
  end

  logic [DEC_W-1:0] gap_q;
  logic             seen_q;
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (last) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != DEC_W'(MIN_DEC)) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_DUMP_SPACING: assert property (@(posedge clk) disable iff (rst)
    last |-> (!seen_q || gap_q >= DEC_W'(MIN_DEC - 1))); // R4
endmodule

// File: rtl/ddc_intdump_lane.sv
module ddc_intdump_lane #(
  parameter int MIX_W = 15,
  parameter int ACC_W = 23,
  parameter int OUT_W = 16,
  parameter int SH_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    adv,
  input  logic                    last,
  input  logic [SH_W-1:0]         shift,
  input  logic signed [MIX_W-1:0] mix_in,
  output logic [OUT_W-1:0]        word_out
);
  localparam logic signed [ACC_W:0] MAXV = (ACC_W+1)'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W:0] MINV = -((ACC_W+1)'(2 ** (OUT_W - 1)));

  logic signed [ACC_W-1:0] acc_q, sum_q, mix_ext, acc_next;
  logic [SH_W-1:0]         sh_q;
  logic [ACC_W:0]          half;
  logic signed [ACC_W:0]   biased, scaled;

  assign mix_ext  = ACC_W'(mix_in);
  assign acc_next = acc_q + mix_ext;

  always_ff @(posedge clk) begin
    if (rst || !en)  acc_q <= '0;
    else if (adv)    acc_q <= last ? '0 : acc_next;
  end

  always_ff @(posedge clk) begin
    if (last) begin
      sum_q <= acc_next;
      sh_q  <= shift;
    end
  end

  always_comb begin
    half   = ((ACC_W+1)'(1) << sh_q) >> 1;
    biased = $signed({sum_q[ACC_W-1], sum_q}) + $signed(half);
    scaled = biased >>> sh_q;
  end

  always_ff @(posedge clk) begin
    if (scaled > MAXV)      word_out <= MAXV[OUT_W-1:0];
    else if (scaled < MINV) word_out <= MINV[OUT_W-1:0];
    else                    word_out <= scaled[OUT_W-1:0];
  end
endmodule

// File: rtl/ddc_interleaver.sv
module ddc_interleaver #(
  parameter int OUT_W = 16,
  parameter int LANES = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic                   load_v,
  input  logic [LANES*OUT_W-1:0] words_in,
  input  logic                   out_ready,
  output logic [OUT_W-1:0]       out_data,
  output logic                   out_valid,
  output logic                   overrun
);
  localparam int RW = $clog2(LANES + 1);

  logic [OUT_W-1:0] slot_q [LANES];
  logic [RW-1:0]    rem_q;
  logic             valid_q, ovr_q, leave, accept;

  assign leave  = valid_q && out_ready;
  assign accept = load_v && ((rem_q == '0) || ((rem_q == RW'(1)) && out_ready));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      rem_q   <= '0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (accept) begin
        rem_q   <= RW'(LANES);
        valid_q <= 1'b1;
      end else if (leave) begin
        rem_q   <= rem_q - 1'b1;
        valid_q <= (rem_q != RW'(1));
      end
      if (load_v && !accept) ovr_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      for (int k = 0; k < LANES; k++) slot_q[k] <= words_in[k*OUT_W +: OUT_W];
    end else if (leave) begin
      for (int k = 0; k < LANES - 1; k++) slot_q[k] <= slot_q[k+1];
    end
  end

  assign out_data  = slot_q[0];
  assign out_valid = valid_q;
  assign overrun   = ovr_q;

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !out_ready && en) |=> (valid_q && $stable(out_data))); // R8
  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!valid_q && !ovr_q)); // R10
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && en) |=> ovr_q); // R9
  AST_START_I1: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_q) |-> (rem_q == RW'(LANES))); // R7
endmodule

// File: rtl/dual_rx_downconv.sv
module dual_rx_downconv import ddc_pkg::*; #(
  parameter int ADC_W   = 14,
  parameter int OUT_W   = 16,
  parameter int PHASE_W = 32,
  parameter int LUT_AW  = 10,
  parameter int LUT_DW  = 16,
  parameter int DEC_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADC_W-1:0]   rx_a,
  input  logic [ADC_W-1:0]   rx_b,
  input  logic [PHASE_W-1:0] phase_inc,
  input  logic [DEC_W-1:0]   dec_rate,
  input  logic               enable,
  input  logic               out_ready,
  output logic [OUT_W-1:0]   out_data,
  output logic               out_valid,
  output logic               overrun
);
  localparam int MIX_W = ADC_W + 1;
  localparam int ACC_W = MIX_W + DEC_W;
  localparam int SH_W  = $clog2(DEC_W);

  logic signed [LUT_DW-1:0] sin_v, cos_v;
  logic                     v1_q, v2_q, v3_q, v4_q;
  logic                     dump_last;
  logic [SH_W-1:0]          dump_shift;
  logic [ADC_W-1:0]         rx_bus [NUM_CH];
  logic signed [MIX_W-1:0]  mix_v  [LANES];
  logic [LANES*OUT_W-1:0]   word_bus;

  assign rx_bus[0] = rx_a;
  assign rx_bus[1] = rx_b;

  ddc_nco #(.PHASE_W(PHASE_W), .LUT_AW(LUT_AW), .LUT_DW(LUT_DW)) u_nco (
    .clk(clk), .rst(rst), .en(enable), .inc(phase_inc),
    .sin_q(sin_v), .cos_q(cos_v)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
      v4_q <= 1'b0;
    end else begin
      v1_q <= enable;
      v2_q <= v1_q && enable;
      v3_q <= dump_last;
      v4_q <= v3_q && enable;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    ddc_mixer #(.ADC_W(ADC_W), .LUT_DW(LUT_DW), .MIX_W(MIX_W)) u_mix (
      .clk(clk), .x_in(rx_bus[ch]), .sin_v(sin_v), .cos_v(cos_v),
      .i_out(mix_v[2*ch]), .q_out(mix_v[2*ch+1])
    );
  end

  ddc_dump_ctrl #(.DEC_W(DEC_W), .MIN_DEC(MIN_DEC), .SH_W(SH_W)) u_ctrl (
    .clk(clk), .rst(rst), .en(enable), .adv(v2_q), .dec_in(dec_rate),
    .last(dump_last), .shift(dump_shift)
  );

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    ddc_intdump_lane #(.MIX_W(MIX_W), .ACC_W(ACC_W), .OUT_W(OUT_W), .SH_W(SH_W)) u_lane (
      .clk(clk), .rst(rst), .en(enable), .adv(v2_q), .last(dump_last),
      .shift(dump_shift), .mix_in(mix_v[ln]),
      .word_out(word_bus[ln*OUT_W +: OUT_W])
    );
  end

  ddc_interleaver #(.OUT_W(OUT_W), .LANES(LANES)) u_ilv (
    .clk(clk), .rst(rst), .en(enable), .load_v(v4_q), .words_in(word_bus),
    .out_ready(out_ready), .out_data(out_data), .out_valid(out_valid),
    .overrun(overrun)
  );

  AST_DISABLED_NO_DUMP: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !v4_q); // R10
endmodule

// File: tb/sim_dual_rx_downconv.sv
module sim_dual_rx_downconv;
  localparam int ADC_W = 16, OUT_W = 16, DEC_W = 8;

  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic [ADC_W-1:0] rx_a = '0, rx_b = '0;
  logic [31:0]      phase_inc = '0;
  logic [DEC_W-1:0] dec_rate = 8'd8;
  logic             enable = 1'b0, out_ready = 1'b1;
  wire  [OUT_W-1:0] out_data;
  wire              out_valid, overrun;

  int n_chk = 0, n_fail = 0;
  string tag = "R10";
  bit done = 1'b0, cmp_on = 1'b0;
  int amode = 0, rmode = 0;

  dual_rx_downconv #(.ADC_W(ADC_W), .OUT_W(OUT_W), .DEC_W(DEC_W)) u0 (
    .clk(clk), .rst(rst), .rx_a(rx_a), .rx_b(rx_b), .phase_inc(phase_inc),
    .dec_rate(dec_rate), .enable(enable), .out_ready(out_ready),
    .out_data(out_data), .out_valid(out_valid), .overrun(overrun)
  );

  function automatic int tab(input int k);
    real v;
    v = 32767.0 * $sin(2.0 * 3.14159265358979 * real'(k) / real'(1024));
    return $rtoi($floor(v + 0.5));
  endfunction
  function automatic int clampd(input int d); return (d < 8) ? 8 : d; endfunction
  function automatic int flog2(input int d);
    int r = 0;
    for (int i = 0; i < 31; i++) if (d >= (1 << i)) r = i;
    return r;
  endfunction
  function automatic int scale(input int s, input int sh);
    int r;
    r = (sh > 0) ? ((s + (1 << (sh - 1))) >>> sh) : s;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  // behavioural reference, one update per clock
  bit [31:0] m_phase;
  int m_x1[2], m_sin1, m_cos1, m_mix[4], m_acc[4], m_sum3[4], m_w4[4], m_slot[4];
  int m_cnt, m_cur, m_sh3, m_rem;
  bit m_v1, m_v2, m_v3, m_v4, m_ovr;

  always @(posedge clk) begin : model
    bit last, accept, leave;
    int a;
    leave  = (m_rem != 0) && out_ready;
    accept = m_v4 && (m_rem == 0 || (m_rem == 1 && out_ready));
    if (rst || !enable) begin m_rem = 0; m_ovr = 0; end
    else begin
      if (accept) begin
        for (int k = 0; k < 4; k++) m_slot[k] = m_w4[k];
        m_rem = 4;
      end else if (leave) begin
        for (int k = 0; k < 3; k++) m_slot[k] = m_slot[k+1];
        m_rem = m_rem - 1;
      end
      if (m_v4 && !accept) m_ovr = 1;
    end
    for (int k = 0; k < 4; k++) m_w4[k] = scale(m_sum3[k], m_sh3);
    m_v4 = !rst && m_v3 && enable;
    last = !rst && enable && m_v2 && (m_cnt == m_cur - 1);
    if (last) begin
      for (int k = 0; k < 4; k++) m_sum3[k] = m_acc[k] + m_mix[k];
      m_sh3 = flog2(m_cur);
    end
    m_v3 = last;
    if (rst || !enable) begin
      m_cnt = 0;
      m_cur = rst ? 8 : clampd(int'(dec_rate));
      for (int k = 0; k < 4; k++) m_acc[k] = 0;
    end else if (m_v2) begin
      if (last) begin
        m_cnt = 0;
        m_cur = clampd(int'(dec_rate));
        for (int k = 0; k < 4; k++) m_acc[k] = 0;
      end else begin
        m_cnt = m_cnt + 1;
        for (int k = 0; k < 4; k++) m_acc[k] = m_acc[k] + m_mix[k];
      end
    end
    for (int c = 0; c < 2; c++) begin
      m_mix[2*c]   = (m_x1[c] * m_cos1) >>> 15;
      m_mix[2*c+1] = (-(m_x1[c] * m_sin1)) >>> 15;
    end
    m_v2 = !rst && m_v1 && enable;
    m_x1[0] = int'($signed(rx_a));
    m_x1[1] = int'($signed(rx_b));
    a = int'(m_phase[31:22]);
    m_sin1 = tab(a);
    m_cos1 = tab((a + 256) % 1024);
    m_v1 = !rst && enable;
    m_phase = (rst || !enable) ? 32'd0 : m_phase + phase_inc;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check(out_valid == (m_rem != 0), tag, int'(out_valid), int'(m_rem != 0));
      check(overrun == m_ovr, tag, int'(overrun), int'(m_ovr));
      if (out_valid && m_rem != 0)
        check(int'($signed(out_data)) == m_slot[0], tag, int'($signed(out_data)), m_slot[0]);
    end
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      case (amode)
        1:       begin rx_a = 16'h7fff; rx_b = 16'h8000; end
        2:       begin rx_a = 16'h8000; rx_b = 16'h7fff; end
        default: begin rx_a = 16'($urandom); rx_b = 16'($urandom); end
      endcase
      case (rmode)
        1:       out_ready = 1'($urandom);
        2:       out_ready = 1'b0;
        default: out_ready = 1'b1;
      endcase
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cmp_on = 1'b1;
    check(out_valid == 1'b0, "R10 reset valid", int'(out_valid), 0);
    check(overrun == 1'b0, "R10 reset overrun", int'(overrun), 0);

    tag = "R1 R2 R3 R7";
    phase_inc = 32'h0123_4567; dec_rate = 8'd8; enable = 1'b1;
    run(300);

    tag = "R4";
    dec_rate = 8'd3;
    run(300);

    tag = "R5";
    dec_rate = 8'd13;
    run(150);
    dec_rate = 8'd20;
    run(150);

    tag = "R6";
    phase_inc = 32'd0; dec_rate = 8'd15; amode = 1;
    run(200);
    amode = 2;
    run(200);

    tag = "R8";
    amode = 0; phase_inc = 32'h0555_0000; dec_rate = 8'd8; rmode = 1;
    run(400);

    tag = "R9";
    rmode = 2;
    run(60);
    check(overrun == 1'b1, "R9 overrun set", int'(overrun), 1);
    rmode = 0;
    run(100);

    tag = "R10";
    enable = 1'b0;
    run(5);
    check(out_valid == 1'b0, "R10 disabled valid", int'(out_valid), 0);
    check(overrun == 1'b0, "R10 disabled overrun", int'(overrun), 0);
    enable = 1'b1;
    run(200);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule